// File: doc/BRIEF.md
# Four-Thread Switch-on-Stall Selector

This block decides which of four hardware threads owns a shared in-order issue pipeline. Every thread keeps its own register bank and its own instruction buffer, and reports three flags each cycle: instructions ready, a stall that blocks issue, and an empty buffer. The owning thread keeps the pipeline until its stall flag or its empty flag is raised. It is never taken away on a time slice.

When the owner is blocked, the selector searches the other threads in rotating order, starting at the thread numbered one above the owner and wrapping past the highest number. It hands the pipeline to the first thread that can issue. The new owner number, a one-hot register-bank select and a one-cycle switch pulse all appear together after the next rising clock edge. If no other thread can issue, ownership stays where it is. An idle flag is raised in that same cycle so that the issue stage inserts a bubble.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level-sensitive control or status signal, sampled on the rising edge of `clk`.

Top module: `thread_switch_sel`

## Requirements
- R1: While `rst_n` is low, and at the first edge after its release, `active_tid` is 0, `bank_sel` is 4'b0001 and `switch_pulse` is 0, whatever the thread flags show.
- R2: When the owner has neither its stall bit nor its empty bit set, ownership is unchanged after the edge, `switch_pulse` stays 0 and `idle` is 0, whatever the other threads show.
- R3: When the owner's stall bit is set and at least one other thread is a candidate, ownership moves to another thread at the next rising edge.
- R4: When the owner's empty bit is set and at least one other thread is a candidate, ownership moves to another thread at the next rising edge.
- R5: A thread is a candidate only if its ready bit is 1, its stall bit is 0 and its empty bit is 0. The owner itself is never a candidate.
- R6: Among the candidates, the winner is the first one met when counting upward from owner+1, wrapping modulo 4.
- R7: When the owner is blocked and no other thread is a candidate, `idle` is 1 in that same cycle, ownership is unchanged after the edge and `switch_pulse` stays 0.
- R8: `switch_pulse` is 1 for exactly the cycle that follows an edge where ownership changed, and is 0 in every other cycle.
- R9: `bank_sel` is one-hot, with bit `active_tid` set and all other bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | 4 | Per-thread flag: instructions ready to issue (bit i = thread i) |
| thr_stall | input | 4 | Per-thread flag: the next instruction cannot issue |
| thr_empty | input | 4 | Per-thread flag: the instruction buffer holds nothing |
| active_tid | output | 2 | Number of the thread that owns the pipeline |
| bank_sel | output | 4 | One-hot register-bank select for the owner |
| switch_pulse | output | 1 | One-cycle marker that ownership has just changed |
| idle | output | 1 | The owner is blocked and no other thread can take over |

## Verification
The bench builds the block at its default of four threads. At that size the flag space is only twelve bits, so it can be covered completely. Every one of the 4096 flag combinations is applied with each of the four threads as owner, and before each combination the bench moves ownership to the intended thread through a forced switch. This covers every wrap-around of the rotating search, every blocked-owner case with and without a candidate, and switches on consecutive cycles.

// File: rtl/thrsel_pkg.sv
package thrsel_pkg;

  // Default thread count of the selector
  localparam int unsigned THRSEL_THREADS_DEF = 4;

  // What the selector does at the coming clock edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,  // owner may keep issuing
    ACT_SWITCH = 2'd1,  // owner blocked, a candidate exists
    ACT_IDLE   = 2'd2   // owner blocked, nobody can take over
  } sel_action_e;

endpackage

// File: rtl/thrsel_eligibility.sv
module thrsel_eligibility #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_stall,
  input  logic [NUM_THREADS-1:0] thr_empty,
  input  logic [TID_W-1:0]       owner,
  output logic [NUM_THREADS-1:0] cand_mask,
  output logic                   owner_blocked
);

  // A thread can take over only if it has work and nothing blocks it;
  // the owner is left out of its own replacement search.
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cand
    assign cand_mask[g] = thr_ready[g] & ~thr_stall[g] & ~thr_empty[g]
                          & (owner != TID_W'(g));
  end

  assign owner_blocked = thr_stall[owner] | thr_empty[owner];

endmodule

// File: rtl/thrsel_rr_pick.sv
module thrsel_rr_pick #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] req,
  input  logic [TID_W-1:0]       base,
  output logic                   found,
  output logic [TID_W-1:0]       pick
);

  // Offsets base+1 .. base+N-1 in turn, wrapped modulo N
  logic [NUM_THREADS-1:0][TID_W-1:0] slot_idx;

  always_comb begin
    for (int k = 0; k < NUM_THREADS; k++) begin
      logic [TID_W:0] sum;
      sum = {1'b0, base} + (TID_W+1)'(k + 1);
      if (sum >= (TID_W+1)'(NUM_THREADS)) begin
        sum = sum - (TID_W+1)'(NUM_THREADS);
      end
      slot_idx[k] = sum[TID_W-1:0];
    end
  end

  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int k = 0; k < NUM_THREADS - 1; k++) begin
      if (!found && req[slot_idx[k]]) begin
        found = 1'b1;
        pick  = slot_idx[k];
      end
    end
  end

endmodule

// File: rtl/thrsel_owner_reg.sv
module thrsel_owner_reg
  import thrsel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  sel_action_e            action,
  input  logic [TID_W-1:0]       next_owner,
  output logic [TID_W-1:0]       owner,
  output logic [NUM_THREADS-1:0] bank_onehot,
  output logic                   pulse
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (action == ACT_SWITCH);
      if (action == ACT_SWITCH) begin
        owner <= next_owner;
      end
    end
  end

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_bank
    assign bank_onehot[g] = (owner == TID_W'(g));
  end

endmodule

// File: rtl/thread_switch_sel.sv
module thread_switch_sel
  import thrsel_pkg::*;
#(
  parameter int unsigned NUM_THREADS = THRSEL_THREADS_DEF,
  localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] thr_ready,
  input  logic [NUM_THREADS-1:0] thr_stall,
  input  logic [NUM_THREADS-1:0] thr_empty,
  output logic [TID_W-1:0]       active_tid,
  output logic [NUM_THREADS-1:0] bank_sel,
  output logic                   switch_pulse,
  output logic                   idle
);

  logic [NUM_THREADS-1:0] cand_mask;
  logic                   owner_blocked;
  logic                   cand_found;
  logic [TID_W-1:0]       cand_pick;
  sel_action_e            action;

  thrsel_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thr_ready     (thr_ready),
    .thr_stall     (thr_stall),
    .thr_empty     (thr_empty),
    .owner         (active_tid),
    .cand_mask     (cand_mask),
    .owner_blocked (owner_blocked)
  );

  thrsel_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .req   (cand_mask),
    .base  (active_tid),
    .found (cand_found),
    .pick  (cand_pick)
  );

  always_comb begin
    if (!owner_blocked)  action = ACT_HOLD;
    else if (cand_found) action = ACT_SWITCH;
    else                 action = ACT_IDLE;
  end

  thrsel_owner_reg #(.NUM_THREADS(NUM_THREADS)) u_owner (
    .clk         (clk),
    .rst_n       (rst_n),
    .action      (action),
    .next_owner  (cand_pick),
    .owner       (active_tid),
    .bank_onehot (bank_sel),
    .pulse       (switch_pulse)
  );

  assign idle = (action == ACT_IDLE);

endmodule

// File: rtl/thrsel_checker.sv
module thrsel_checker #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W = $clog2(NUM_THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_THREADS-1:0] thr_ready,
  input logic [NUM_THREADS-1:0] thr_stall,
  input logic [NUM_THREADS-1:0] thr_empty,
  input logic [TID_W-1:0]       active_tid,
  input logic [NUM_THREADS-1:0] bank_sel,
  input logic                   switch_pulse,
  input logic                   idle
);

  logic [NUM_THREADS-1:0] prv_ready, prv_stall, prv_empty;
  logic [TID_W-1:0]       prv_tid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_ready <= '0;
      prv_stall <= '1;
      prv_empty <= '1;
      prv_tid   <= '0;
    end else begin
      prv_ready <= thr_ready;
      prv_stall <= thr_stall;
      prv_empty <= thr_empty;
      prv_tid   <= active_tid;
    end
  end

  AST_RESET_OWNER: assert property (@(posedge clk)
    !rst_n |-> (active_tid == '0) && !switch_pulse); // R1

  AST_HOLD_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(thr_stall[active_tid] || thr_empty[active_tid])
      |=> $stable(active_tid) && !switch_pulse); // R2

  AST_BLOCKED_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_stall[active_tid] || thr_empty[active_tid]) && !idle
      |=> active_tid != $past(active_tid)); // R3

  AST_TARGET_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> prv_ready[active_tid] && !prv_stall[active_tid]
                     && !prv_empty[active_tid]); // R5

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(active_tid) && !switch_pulse); // R7

  AST_PULSE_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse == (active_tid != prv_tid)); // R8

  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel) && bank_sel[active_tid]); // R9

endmodule

bind thread_switch_sel thrsel_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (.*);

// File: tb/thread_switch_sel_test.sv
`timescale 1ns/1ps
module thread_switch_sel_test;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] rdy = '0, stl = '0, emp = '0;
  logic [1:0]   active_tid;
  logic [N-1:0] bank_sel;
  logic         switch_pulse, idle;

  int checks = 0;
  int errors = 0;
  int cur = 0;

  thread_switch_sel #(.NUM_THREADS(N)) uut (
    .clk(clk), .rst_n(rst_n), .thr_ready(rdy), .thr_stall(stl),
    .thr_empty(emp), .active_tid(active_tid), .bank_sel(bank_sel),
    .switch_pulse(switch_pulse), .idle(idle)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the next falling edge.
  task automatic apply(input logic [N-1:0] r, input logic [N-1:0] s,
                       input logic [N-1:0] e);
    bit blocked, found;
    int nxt;
    string rq;
    rdy = r; stl = s; emp = e;
    blocked = s[cur] | e[cur];
    found = 1'b0;
    nxt = cur;
    for (int k = 1; k < N; k++) begin
      int j;
      j = (cur + k) % N;
      if (!found && r[j] && !s[j] && !e[j]) begin   // R5 candidate rule
        found = 1'b1;
        nxt = j;
      end
    end
    if (!blocked) begin
      nxt = cur; rq = "R2";
    end else if (!found) begin
      rq = "R7";
    end else if (s[cur]) begin
      rq = "R3 R5 R6";
    end else begin
      rq = "R4 R5 R6";
    end
    #1;
    chk(idle == (blocked && !found), blocked ? "R7" : "R2", "idle",
        int'(idle), int'(blocked && !found));
    @(negedge clk);
    chk(int'(active_tid) == nxt, rq, "active_tid", int'(active_tid), nxt);
    chk(switch_pulse == (nxt != cur), "R8", "switch_pulse",
        int'(switch_pulse), int'(nxt != cur));
    chk(bank_sel == (N'(1) << nxt), "R9", "bank_sel",
        int'(bank_sel), int'(N'(1) << nxt));
    cur = nxt;
  endtask

  initial begin
    // R1: flags that would force a switch are ignored under reset
    rdy = '1; stl = 4'b0001; emp = '0;
    repeat (3) @(negedge clk);
    chk(active_tid == 2'd0, "R1", "active_tid in reset", int'(active_tid), 0);
    chk(bank_sel == 4'b0001, "R1", "bank_sel in reset", int'(bank_sel), 1);
    chk(switch_pulse == 1'b0, "R1", "pulse in reset", int'(switch_pulse), 0);
    rdy = '0; stl = '0; emp = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(active_tid == 2'd0, "R1", "active_tid after release", int'(active_tid), 0);
    chk(switch_pulse == 1'b0, "R1", "pulse after release", int'(switch_pulse), 0);
    cur = 0;

    for (int c = 0; c < N; c++) begin
      for (int v = 0; v < 4096; v++) begin
        if (cur != c) begin
          // force a stall-driven switch straight to thread c (R3)
          apply(N'(1) << c, N'(1) << cur, '0);
        end
        apply(v[3:0], v[7:4], v[11:8]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule